// File: doc/BRIEF.md
# Multi-Channel Timer with Up/Down PWM Mode

The block is a timer in which a single 16-bit counter feeds a configurable set of channels. Each channel is set up on its own to take a timestamp of pin edges, to toggle its pin when the counter hits a programmed value, or to drive a PWM waveform aligned to the start of each counter period. A single global mode bit changes the counter into an up/down counter. In that mode every enabled channel produces a PWM waveform symmetric about the counter's bottom point, and the per-channel capture, compare and edge-PWM behaviour is suppressed.

The counter advances on every bus clock, or on rising edges of an external clock input after a two-flop synchronizer. Software uses a flat register interface: a write port, and a read port whose data depends only on the read address. Modulo and channel compare writes go to shadow registers. These shadow values reach the active registers only at the period boundary, or at once while the counter is stopped. Each channel drives a pin output together with an ownership signal. When that signal is low, the pin stays under general-purpose control.

Register map (5-bit address): 0 control (bit 0 run, bit 1 external clock select, bit 2 up/down mode), 1 modulo, 2 status (bits NCH-1..0 channel flags, bit 15 period flag, write 1 to clear), 3 counter (a write loads it and sets the direction to up), 8+n channel n config (bits 1:0 function: 0 off, 1 capture, 2 compare, 3 edge PWM; bits 3:2 capture edge: bit 2 rising, bit 3 falling), 16+n channel n value.

Top module: `ctr_pwm_timer`

## Requirements
- R1: After reset the control and status registers and the counter read 0, the modulo reads 0xFFFF, every pin ownership bit is 0 and the period flag output is 0.
- R2: With the up/down bit clear, each tick moves the counter from 0 up to the active modulo and then to 0. That wrap sets status bit 15 and the period flag output, and writing 1 to bit 15 clears it. A stopped counter holds its value.
- R3: With the up/down bit set, the counter goes 0,1,…,M,M-1,…,1,0,1,… for modulo M. Status bit 15 is set at the step that leaves 0 while counting down.
- R4: A channel in edge PWM function (code 3) drives its pin high exactly while the counter is below its active value. A value of 0 keeps it low, and a value above the modulo keeps it high.
- R5: In up/down mode an enabled channel drives high while the counter is below its active value. A value of 0 keeps it low, and a value at or above the modulo keeps it high.
- R6: A channel in compare function (code 2) toggles its pin and sets its status flag on the tick at which the counter equals its active value.
- R7: A channel in capture function (code 1) copies the counter into its value register and sets its flag on a synchronized pin edge selected by config bit 2 (rising) or bit 3 (falling). With neither bit set, no edge captures.
- R8: Modulo and channel value writes made while running take effect only at the wrap (up mode) or bottom turnaround (up/down mode). Writes made while stopped take effect immediately.
- R9: With external clock select set, the counter advances once per rising edge of the external clock input and holds while that input is steady.
- R10: In up/down mode no channel captures or raises a flag, whatever its function code.
- R11: A pin ownership bit is 1 only for a channel in compare or edge PWM function, or, in up/down mode, for any channel whose function is not off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 5 | Register read address |
| rdData | output | 16 | Register read data for rdAddr |
| extClk | input | 1 | External counter clock, asynchronous |
| pinIn | input | NCH | Channel pin inputs, asynchronous |
| pinOut | output | NCH | Channel pin outputs |
| pinOe | output | NCH | Channel pin ownership |
| ovfFlag | output | 1 | Period flag (status bit 15) |

## Verification
Edge PWM is run with a mid-range value, with 0, and with a value above the modulo. This separates the plain comparison from the two saturating ends. Up/down PWM uses the same three classes with a value equal to the modulo, which tells the at-or-above rule apart from the edge rule. Capture is driven with rising and falling pin edges under each edge select code, so a missing or swapped polarity shows up as a wrong or absent timestamp. Shadowed modulo and value writes land in the middle of a period, so an early load shows up as a changed wrap point or duty before the boundary.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int MAX_CH = 8;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_MOD  = 5'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 5'd3;
  localparam int A_CFG = 8;
  localparam int A_VAL = 16;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_CAPT = 2'd1,
    CH_CMP  = 2'd2,
    CH_EPWM = 2'd3
  } chMode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic              modWr;
    logic              cntWr;
    logic [MAX_CH-1:0] valWr;
    logic [CNT_W-1:0]  data;
  } ctlStrobe_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             loadEn,
  input  logic             center,
  input  logic [1:0]       mode,
  input  logic [1:0]       edgeSel,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] modAct,
  input  logic             valWr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             pinIn,
  output logic             pinOut,
  output logic             pinOe,
  output logic [CNT_W-1:0] valBuf,
  output logic             evt
);
  logic [2:0]       pinSh;
  logic [CNT_W-1:0] valAct;
  logic             cmpOut;
  logic             riseHit, fallHit, capEvt, cmpEvt;

  always_ff @(posedge clk) begin
    if (rst) pinSh <= '0;
    else     pinSh <= {pinSh[1:0], pinIn};
  end

  assign riseHit = pinSh[1] & ~pinSh[2];
  assign fallHit = ~pinSh[1] & pinSh[2];
  assign capEvt  = !center && (mode == CH_CAPT) &&
                   ((edgeSel[0] && riseHit) || (edgeSel[1] && fallHit));
  assign cmpEvt  = !center && (mode == CH_CMP) && tick && (cntVal == valAct);
  assign evt     = capEvt | cmpEvt;

  always_ff @(posedge clk) begin
    if (rst) begin
      valBuf <= '0;
      valAct <= '0;
      cmpOut <= 1'b0;
    end else begin
      if (capEvt)     valBuf <= cntVal;
      else if (valWr) valBuf <= wrData;
      if (loadEn)     valAct <= valBuf;
      if (cmpEvt)     cmpOut <= ~cmpOut;
    end
  end

  always_comb begin
    pinOut = 1'b0;
    pinOe  = 1'b0;
    if (center) begin
      pinOe  = (mode != CH_OFF);
      pinOut = pinOe && (valAct != '0) && ((valAct >= modAct) || (cntVal < valAct));
    end else begin
      case (mode)
        CH_CMP:  begin pinOe = 1'b1; pinOut = cmpOut; end
        CH_EPWM: begin pinOe = 1'b1; pinOut = (cntVal < valAct); end
        default: begin pinOe = 1'b0; pinOut = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NCH = 4
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [CNT_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [CNT_W-1:0]          rdData,
  input  logic [CNT_W-1:0]          cntVal,
  input  logic [CNT_W-1:0]          modBuf,
  input  logic [NCH-1:0][CNT_W-1:0] valBuf,
  input  logic                      ovfEvt,
  input  logic [NCH-1:0]            chEvt,
  output ctlStrobe_t                cs,
  output logic                      run,
  output logic                      extSel,
  output logic                      center,
  output logic [NCH-1:0][1:0]       chMode,
  output logic [NCH-1:0][1:0]       chEdge,
  output logic                      ovfFlag,
  output logic [NCH-1:0]            chFlags
);
  localparam int OVF_BIT = CNT_W - 1;

  logic stClr;

  always_comb begin
    cs       = '0;
    cs.data  = wrData;
    cs.modWr = wrEn && (wrAddr == A_MOD);
    cs.cntWr = wrEn && (wrAddr == A_CNT);
    for (int n = 0; n < NCH; n++)
      cs.valWr[n] = wrEn && (wrAddr == ADDR_W'(A_VAL + n));
  end

  assign stClr = wrEn && (wrAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      extSel  <= 1'b0;
      center  <= 1'b0;
      chMode  <= '0;
      chEdge  <= '0;
      ovfFlag <= 1'b0;
      chFlags <= '0;
    end else begin
      if (wrEn && (wrAddr == A_CTRL)) begin
        run    <= wrData[0];
        extSel <= wrData[1];
        center <= wrData[2];
      end
      for (int n = 0; n < NCH; n++) begin
        if (wrEn && (wrAddr == ADDR_W'(A_CFG + n))) begin
          chMode[n] <= wrData[1:0];
          chEdge[n] <= wrData[3:2];
        end
      end
      // a new event wins over a clear in the same cycle
      ovfFlag <= ovfEvt | (ovfFlag & ~(stClr & wrData[OVF_BIT]));
      chFlags <= chEvt | (chFlags & ~({NCH{stClr}} & wrData[NCH-1:0]));
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL: rdData[2:0] = {center, extSel, run};
      A_MOD:  rdData = modBuf;
      A_STAT: begin
        rdData[NCH-1:0] = chFlags;
        rdData[OVF_BIT] = ovfFlag;
      end
      A_CNT:  rdData = cntVal;
      default: begin
        for (int n = 0; n < NCH; n++) begin
          if (rdAddr == ADDR_W'(A_CFG + n)) rdData[3:0] = {chEdge[n], chMode[n]};
          if (rdAddr == ADDR_W'(A_VAL + n)) rdData = valBuf[n];
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NCH = 4
)(
  input  logic                      clk,
  input  logic                      rst,
  input  ctlStrobe_t                cs,
  input  logic                      run,
  input  logic                      extSel,
  input  logic                      center,
  input  logic [NCH-1:0][1:0]       chMode,
  input  logic [NCH-1:0][1:0]       chEdge,
  input  logic                      extClk,
  input  logic [NCH-1:0]            pinIn,
  output logic [NCH-1:0]            pinOut,
  output logic [NCH-1:0]            pinOe,
  output logic [CNT_W-1:0]          cntVal,
  output logic [CNT_W-1:0]          modBuf,
  output logic [CNT_W-1:0]          modAct,
  output logic [NCH-1:0][CNT_W-1:0] valBuf,
  output logic                      ovfEvt,
  output logic [NCH-1:0]            chEvt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [2:0]       extSh;
  logic             extRise, tick, loadEn, dirUp, upNext, evt;
  logic [CNT_W-1:0] cntNext;
  logic             unusedValWr;

  assign unusedValWr = ^cs.valWr;

  always_ff @(posedge clk) begin
    if (rst) extSh <= '0;
    else     extSh <= {extSh[1:0], extClk};
  end

  assign extRise = extSh[1] & ~extSh[2];
  assign tick    = run & (extSel ? extRise : 1'b1);

  always_comb begin
    cntNext = cntVal;
    upNext  = dirUp;
    evt     = 1'b0;
    if (cs.cntWr) begin
      cntNext = cs.data;
      upNext  = 1'b1;
    end else if (tick) begin
      if (!center) begin
        upNext = 1'b1;
        if (cntVal >= modAct) begin
          cntNext = '0;
          evt     = 1'b1;
        end else begin
          cntNext = cntVal + ONE;
        end
      end else if (modAct == '0) begin
        cntNext = '0;
        upNext  = 1'b1;
        evt     = 1'b1;
      end else if (dirUp) begin
        if (cntVal >= modAct) begin
          cntNext = cntVal - ONE;
          upNext  = 1'b0;
        end else begin
          cntNext = cntVal + ONE;
        end
      end else if (cntVal == '0) begin
        cntNext = ONE;
        upNext  = 1'b1;
        evt     = 1'b1;
      end else begin
        cntNext = cntVal - ONE;
      end
    end
  end

  assign loadEn = evt | ~run;
  assign ovfEvt = evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal <= '0;
      dirUp  <= 1'b1;
      modBuf <= '1;
      modAct <= '1;
    end else begin
      cntVal <= cntNext;
      dirUp  <= upNext;
      if (cs.modWr) modBuf <= cs.data;
      if (loadEn)   modAct <= modBuf;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    tmr_chan i_chan (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .loadEn (loadEn),
      .center (center),
      .mode   (chMode[n]),
      .edgeSel(chEdge[n]),
      .cntVal (cntVal),
      .modAct (modAct),
      .valWr  (cs.valWr[n]),
      .wrData (cs.data),
      .pinIn  (pinIn[n]),
      .pinOut (pinOut[n]),
      .pinOe  (pinOe[n]),
      .valBuf (valBuf[n]),
      .evt    (chEvt[n])
    );
  end
endmodule

// File: rtl/ctr_pwm_timer.sv
module ctr_pwm_timer
  import tmr_pkg::*;
#(
  parameter int NCH = 4  // 1 to MAX_CH channels
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [15:0]       wrData,
  input  logic [4:0]        rdAddr,
  output logic [15:0]       rdData,
  input  logic              extClk,
  input  logic [NCH-1:0]    pinIn,
  output logic [NCH-1:0]    pinOut,
  output logic [NCH-1:0]    pinOe,
  output logic              ovfFlag
);
  ctlStrobe_t               cs;
  logic                     run, extSel, center, ovfEvt;
  logic [NCH-1:0][1:0]      chMode, chEdge;
  logic [NCH-1:0]           chFlags, chEvt;
  logic [CNT_W-1:0]         cntVal, modBuf, modAct;
  logic [NCH-1:0][CNT_W-1:0] valBuf;

  tmr_ctrl #(.NCH(NCH)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .cntVal (cntVal),
    .modBuf (modBuf),
    .valBuf (valBuf),
    .ovfEvt (ovfEvt),
    .chEvt  (chEvt),
    .cs     (cs),
    .run    (run),
    .extSel (extSel),
    .center (center),
    .chMode (chMode),
    .chEdge (chEdge),
    .ovfFlag(ovfFlag),
    .chFlags(chFlags)
  );

  tmr_datapath #(.NCH(NCH)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .cs     (cs),
    .run    (run),
    .extSel (extSel),
    .center (center),
    .chMode (chMode),
    .chEdge (chEdge),
    .extClk (extClk),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .cntVal (cntVal),
    .modBuf (modBuf),
    .modAct (modAct),
    .valBuf (valBuf),
    .ovfEvt (ovfEvt),
    .chEvt  (chEvt)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NCH = 4
)(
  input logic                clk,
  input logic                rst,
  input ctlStrobe_t          cs,
  input logic                run,
  input logic                extSel,
  input logic                center,
  input logic [NCH-1:0][1:0] chMode,
  input logic [NCH-1:0]      pinOe,
  input logic [CNT_W-1:0]    cntVal,
  input logic [CNT_W-1:0]    modAct,
  input logic                ovfEvt,
  input logic                ovfFlag,
  input logic [NCH-1:0]      chEvt,
  input logic [NCH-1:0]      chFlags
);
  logic [NCH-1:0] idleMask;

  always_comb begin
    for (int n = 0; n < NCH; n++)
      idleMask[n] = (chMode[n] == CH_OFF) || (!center && chMode[n] == CH_CAPT);
  end

  // R11: channels without an output function never own their pin
  p_pin_owner_r11: assert property (@(posedge clk) disable iff (rst)
    (pinOe & idleMask) == '0);

  // R2: up-mode wrap at the active modulo
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !extSel && !center && !cs.cntWr && cntVal >= modAct) |=> (cntVal == '0));

  // R2: a stopped counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !cs.cntWr) |=> $stable(cntVal));

  // R2: the period event always reaches the flag
  p_ovf_flag_r2: assert property (@(posedge clk) disable iff (rst)
    ovfEvt |=> ovfFlag);

  // R3: the up/down counter turns back below the modulo
  p_turn_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !extSel && center && !cs.cntWr && modAct != '0 && cntVal == modAct)
    |=> (cntVal == $past(modAct) - CNT_W'(1)));

  // R10: up/down mode silences all channel events
  p_center_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    center |-> (chEvt == '0));

  // R6: channel events always raise their flags
  p_chan_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (chEvt != '0) |=> ((chFlags & $past(chEvt)) == $past(chEvt)));
endmodule

bind ctr_pwm_timer tmr_checker #(.NCH(NCH)) i_tmr_checker (
  .clk    (clk),
  .rst    (rst),
  .cs     (cs),
  .run    (run),
  .extSel (extSel),
  .center (center),
  .chMode (chMode),
  .pinOe  (pinOe),
  .cntVal (cntVal),
  .modAct (modAct),
  .ovfEvt (ovfEvt),
  .ovfFlag(ovfFlag),
  .chEvt  (chEvt),
  .chFlags(chFlags)
);

// File: tb/test_ctr_pwm_timer.sv
`timescale 1ns/1ps
module test_ctr_pwm_timer;
  localparam int NCH = 4;
  localparam logic [4:0] R_CTRL = 5'd0, R_MOD = 5'd1, R_STAT = 5'd2, R_CNT = 5'd3;
  localparam int R_CFG = 8, R_VAL = 16;
  localparam int K_REG = 0, K_PIN = 1, K_OE = 2, K_OVF = 3, K_PWM = 4;

  logic clk = 1'b0, rst = 1'b1, wrEn = 1'b0, extClk = 1'b0;
  logic [4:0] wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0, rdData;
  logic [NCH-1:0] pinIn = '0, pinOut, pinOe;
  logic ovfFlag;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctr_pwm_timer #(.NCH(NCH)) i_ctr_pwm_timer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extClk(extClk), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .ovfFlag(ovfFlag)
  );

  typedef struct {
    int          kind;
    int          idx;
    logic [15:0] exp;
    int          cv;
    int          md;
    bit          ctr;
    string       tag;
  } item_t;
  item_t sbq[$];

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    item_t it;
    logic [15:0] act, expv;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      expv = it.exp;
      case (it.kind)
        K_REG: act = rdData;
        K_PIN: act = {15'd0, pinOut[it.idx]};
        K_OE:  act = {15'd0, pinOe[it.idx]};
        K_OVF: act = {15'd0, ovfFlag};
        default: begin
          act = {15'd0, pinOut[it.idx]};
          if (it.ctr)
            expv = {15'd0, (it.cv != 0) && (it.cv >= it.md || int'(rdData) < it.cv)};
          else
            expv = {15'd0, int'(rdData) < it.cv};
        end
      endcase
      vectors++;
      if (act !== expv) begin
        fails++;
        $display("FAIL %s: kind %0d idx %0d actual %h expected %h", it.tag, it.kind, it.idx, act, expv);
      end
    end
  end

  task automatic push(int kind, int idx, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.cv = 0; it.md = 0; it.ctr = 0; it.tag = tag;
    if (kind == K_REG) rdAddr = idx[4:0];
    sbq.push_back(it);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic expect_it(int kind, int idx, logic [15:0] exp, string tag);
    push(kind, idx, exp, tag);
    step();
  endtask

  task automatic expect_pwm(int ch, int cv, int md, bit ctr, int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.kind = K_PWM; it.idx = ch; it.exp = '0; it.cv = cv; it.md = md; it.ctr = ctr; it.tag = tag;
      rdAddr = R_CNT;
      sbq.push_back(it);
      step();
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic start(logic [15:0] md, logic [15:0] ctl);
    wr(R_MOD, md);
    wr(R_CNT, 16'd0);
    wr(R_STAT, 16'hFFFF);
    wr(R_CTRL, ctl);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    step();

    // R1 reset state
    expect_it(K_REG, R_CTRL, 16'h0000, "R1");
    expect_it(K_REG, R_STAT, 16'h0000, "R1");
    expect_it(K_REG, R_CNT, 16'h0000, "R1");
    expect_it(K_REG, R_MOD, 16'hFFFF, "R1");
    expect_it(K_OVF, 0, 16'd0, "R1");
    for (int n = 0; n < NCH; n++) expect_it(K_OE, n, 16'd0, "R1");

    // R2 up-mode wrap and flag
    start(16'd3, 16'h0001);
    for (int i = 0; i < 4; i++) begin
      if (i == 3) push(K_OVF, 0, 16'd0, "R2");
      expect_it(K_REG, R_CNT, 16'(i), "R2");
    end
    push(K_OVF, 0, 16'd1, "R2");
    expect_it(K_REG, R_CNT, 16'd0, "R2");
    expect_it(K_REG, R_CNT, 16'd1, "R2");
    wr(R_CTRL, 16'h0000);
    expect_it(K_REG, R_STAT, 16'h8000, "R2");
    wr(R_STAT, 16'h8000);
    expect_it(K_REG, R_STAT, 16'h0000, "R2");
    wait_cyc(4);
    expect_it(K_REG, R_CNT, 16'd3, "R2 hold");

    // R3 up/down sequence
    start(16'd4, 16'h0005);
    begin
      int seq[11] = '{0, 1, 2, 3, 4, 3, 2, 1, 0, 1, 2};
      for (int i = 0; i < 11; i++) begin
        if (i == 4) push(K_OVF, 0, 16'd0, "R3");
        if (i == 9) push(K_OVF, 0, 16'd1, "R3");
        expect_it(K_REG, R_CNT, 16'(seq[i]), "R3");
      end
    end
    wr(R_CTRL, 16'h0000);

    // R4 edge PWM and R11 ownership
    wr(5'(R_CFG + 0), 16'h0003);
    wr(5'(R_VAL + 0), 16'd4);
    start(16'd9, 16'h0001);
    expect_pwm(0, 4, 9, 0, 20, "R4");
    expect_it(K_OE, 0, 16'd1, "R11");
    expect_it(K_OE, 3, 16'd0, "R11");
    wr(R_CTRL, 16'h0000);
    wr(5'(R_VAL + 0), 16'd0);
    start(16'd9, 16'h0001);
    expect_pwm(0, 0, 9, 0, 10, "R4 zero");
    wr(R_CTRL, 16'h0000);
    wr(5'(R_VAL + 0), 16'd10);
    start(16'd9, 16'h0001);
    expect_pwm(0, 10, 9, 0, 10, "R4 full");

    // R8 buffered value write
    wr(R_CTRL, 16'h0000);
    wr(5'(R_VAL + 0), 16'd3);
    start(16'd9, 16'h0001);
    wr(5'(R_VAL + 0), 16'd8);
    expect_pwm(0, 3, 9, 0, 8, "R8 old value");
    expect_pwm(0, 8, 9, 0, 10, "R8 new value");

    // R8 buffered modulo write
    wr(R_CTRL, 16'h0000);
    start(16'd9, 16'h0001);
    wr(R_MOD, 16'd5);
    for (int c = 2; c <= 9; c++) expect_it(K_REG, R_CNT, 16'(c), "R8 old modulo");
    for (int c = 0; c <= 5; c++) expect_it(K_REG, R_CNT, 16'(c), "R8 new modulo");
    expect_it(K_REG, R_CNT, 16'd0, "R8 new modulo");

    // R6 output compare
    wr(R_CTRL, 16'h0000);
    wr(5'(R_CFG + 1), 16'h0002);
    wr(5'(R_VAL + 1), 16'd5);
    start(16'd9, 16'h0001);
    for (int i = 0; i < 6; i++) expect_it(K_PIN, 1, 16'd0, "R6");
    for (int i = 0; i < 10; i++) expect_it(K_PIN, 1, 16'd1, "R6");
    expect_it(K_PIN, 1, 16'd0, "R6");
    expect_it(K_REG, R_STAT, 16'h8002, "R6");
    expect_it(K_OE, 1, 16'd1, "R11");
    wr(R_CTRL, 16'h0000);

    // R7 capture
    wr(5'(R_CFG + 2), 16'h0005);
    wr(R_STAT, 16'hFFFF);
    expect_it(K_OE, 2, 16'd0, "R11");
    wr(R_CNT, 16'd100);
    pinIn[2] = 1'b1; wait_cyc(5);
    expect_it(K_REG, 5'(R_VAL + 2), 16'd100, "R7 rising");
    expect_it(K_REG, R_STAT, 16'h0004, "R7");
    wr(R_STAT, 16'h0004);
    wr(R_CNT, 16'd200);
    pinIn[2] = 1'b0; wait_cyc(5);
    expect_it(K_REG, 5'(R_VAL + 2), 16'd100, "R7 falling ignored");
    expect_it(K_REG, R_STAT, 16'h0000, "R7");
    wr(5'(R_CFG + 2), 16'h000D);
    wr(R_CNT, 16'd300);
    pinIn[2] = 1'b1; wait_cyc(5);
    expect_it(K_REG, 5'(R_VAL + 2), 16'd300, "R7 both rising");
    wr(R_CNT, 16'd400);
    pinIn[2] = 1'b0; wait_cyc(5);
    expect_it(K_REG, 5'(R_VAL + 2), 16'd400, "R7 both falling");
    wr(5'(R_CFG + 2), 16'h0001);
    wr(R_STAT, 16'hFFFF);
    wr(R_CNT, 16'd450);
    pinIn[2] = 1'b1; wait_cyc(5);
    pinIn[2] = 1'b0; wait_cyc(5);
    expect_it(K_REG, 5'(R_VAL + 2), 16'd400, "R7 no edge");
    expect_it(K_REG, R_STAT, 16'h0000, "R7 no edge");

    // R10 up/down mode suppresses capture
    wr(5'(R_CFG + 2), 16'h000D);
    wr(R_CTRL, 16'h0004);
    wr(R_CNT, 16'd500);
    pinIn[2] = 1'b1; wait_cyc(5);
    pinIn[2] = 1'b0; wait_cyc(5);
    expect_it(K_REG, 5'(R_VAL + 2), 16'd400, "R10");
    expect_it(K_REG, R_STAT, 16'h0000, "R10");
    expect_it(K_OE, 2, 16'd1, "R11");
    expect_it(K_OE, 3, 16'd0, "R11");

    // R5 up/down PWM
    wr(R_CTRL, 16'h0000);
    wr(5'(R_VAL + 0), 16'd2);
    start(16'd4, 16'h0005);
    expect_pwm(0, 2, 4, 1, 16, "R5");
    wr(R_CTRL, 16'h0000);
    wr(5'(R_VAL + 0), 16'd0);
    start(16'd4, 16'h0005);
    expect_pwm(0, 0, 4, 1, 10, "R5 zero");
    wr(R_CTRL, 16'h0000);
    wr(5'(R_VAL + 0), 16'd4);
    start(16'd4, 16'h0005);
    expect_pwm(0, 4, 4, 1, 10, "R5 full");

    // R9 external clock
    wr(R_CTRL, 16'h0000);
    start(16'd1000, 16'h0003);
    for (int i = 0; i < 5; i++) begin
      extClk = 1'b1; wait_cyc(4);
      extClk = 1'b0; wait_cyc(4);
    end
    wait_cyc(3);
    expect_it(K_REG, R_CNT, 16'd5, "R9");
    extClk = 1'b1; wait_cyc(20);
    expect_it(K_REG, R_CNT, 16'd6, "R9 steady high");
    wait_cyc(10);
    expect_it(K_REG, R_CNT, 16'd6, "R9 steady high");

    step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: all requirements, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule